// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block receives asynchronous serial frames on one input line and places each good character in a holding register for the host logic. The line first passes through a two-stage synchronizer. An internal divider makes a tick at sixteen times the baud rate. A falling edge starts a candidate frame. The candidate becomes a real start bit only if the line is still low at the bit's mid-point. After that, each data bit, the optional parity bit and the stop bit are sampled at their centres. Data arrives least significant bit first.

When the frame is complete, three checks run: parity, first stop bit, and whether the holding register is still occupied. A frame that passes all three sets the full flag and loads the holding register. A frame that fails any check sets only the matching error flags. While any error flag is set, the receiver ignores the line completely, so the host must clear the errors before the next frame can be accepted.

Host logic uses a small write port. One address sets the frame format and the interrupt enable. The other address holds clear strobes for the flags. The holding register and the flags are visible on dedicated outputs at all times, so reading them has no side effect.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, the flags, both interrupt requests and the holding register output are all 0.
- R2: Data bits are assembled least significant bit first. With control bit 0 set (7-bit mode), only 7 data bits are taken, and bit 7 of the holding register reads 0.
- R3: When parity is enabled (control bit 1), a frame sets the parity error flag if data plus parity bit hold an odd count of ones in even mode, or an even count in odd mode (control bit 2 = 1 selects odd).
- R4: A frame whose first stop bit is 0 sets the framing error flag. With two stop bits selected (control bit 3), the level of the second stop bit has no effect.
- R5: A frame that completes while the full flag is 1 sets the overrun flag and leaves the holding register unchanged.
- R6: Only a frame with no error sets the full flag and loads the holding register.
- R7: irq_rxi_o is 1 exactly while the full flag and the interrupt enable (control bit 4) are both 1.
- R8: irq_eri_o is 1 exactly while any error flag is 1 and the interrupt enable is 1.
- R9: While any error flag is 1, frames on the line are ignored. Once all error flags are cleared, reception resumes.
- R10: A low pulse shorter than half a bit time is not taken as a start bit, and the next valid frame is received normally.
- R11: A write to address 1 clears the flags selected by its set bits: bit 0 full, bit 1 overrun, bit 2 parity, bit 3 framing. A write to address 0 loads the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control, 1 = flag clear |
| wdata_i | input | 5 | Write data |
| rdata_o | output | 8 | Holding register |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun error flag |
| per_o | output | 1 | Parity error flag |
| fer_o | output | 1 | Framing error flag |
| irq_rxi_o | output | 1 | Receive-full interrupt request |
| irq_eri_o | output | 1 | Receive-error interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The full flag never rises together with an error flag. Overrun never appears unless the full flag was set. The holding register changes only when the full flag rises. A parity error never appears with parity disabled. The error interrupt never fires with the enable off. A locked, idle receiver stays idle. Other behaviour can only be shown by the bench scenarios: bit ordering, parity polarity, the ignored second stop bit, glitch rejection, and resuming after a clear. For these the bench sends whole frames and compares every output with its own model.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic rie;
    logic stop2;
    logic par_odd;
    logic par_en;
    logic data7;
  } rx_cfg_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              lock_i,
  input  rx_cfg_t           cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bit_o,
  output logic              stop_bit_o,
  output logic              idle_o
);
  localparam int TW = $clog2(OSR + OSR/2);
  localparam int BW = $clog2(DATA_W);
  localparam logic [TW-1:0] MID  = TW'(OSR/2 - 1);
  localparam logic [TW-1:0] FULL = TW'(OSR - 1);
  localparam logic [TW-1:0] TAIL = TW'(OSR + OSR/2 - 1);

  rx_state_e         st_q;
  logic [TW-1:0]     tc_q;
  logic [BW-1:0]     bi_q;
  logic [BW-1:0]     last_bit;

  assign last_bit = cfg_i.data7 ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
  assign idle_o   = (st_q == RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE; tc_q <= '0; bi_q <= '0; data_o <= '0;
      par_bit_o <= 1'b0; stop_bit_o <= 1'b1; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: if (!rx_i && !lock_i) begin st_q <= RX_START; tc_q <= '0; end
          RX_START:
            if (tc_q == MID) begin
              tc_q <= '0; bi_q <= '0; data_o <= '0;
              st_q <= rx_i ? RX_IDLE : RX_DATA;  // reject glitches
            end else tc_q <= tc_q + 1'b1;
          RX_DATA:
            if (tc_q == FULL) begin
              tc_q <= '0;
              data_o[bi_q] <= rx_i;
              if (bi_q == last_bit) st_q <= cfg_i.par_en ? RX_PAR : RX_STOP;
              else                  bi_q <= bi_q + 1'b1;
            end else tc_q <= tc_q + 1'b1;
          RX_PAR:
            if (tc_q == FULL) begin
              tc_q <= '0; par_bit_o <= rx_i; st_q <= RX_STOP;
            end else tc_q <= tc_q + 1'b1;
          RX_STOP:
            if (tc_q == FULL) begin
              tc_q <= '0; stop_bit_o <= rx_i; done_o <= 1'b1;
              st_q <= cfg_i.stop2 ? RX_STOP2 : RX_IDLE;
            end else tc_q <= tc_q + 1'b1;
          RX_STOP2:  // second stop bit: wait out, not checked
            if (tc_q == TAIL) st_q <= RX_IDLE;
            else              tc_q <= tc_q + 1'b1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              stop_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [3:0]        clr_i,
  output logic              full_o,
  output logic              ovr_o,
  output logic              per_o,
  output logic              fer_o,
  output logic [DATA_W-1:0] rdr_o
);
  logic per_n, fer_n;
  assign per_n = par_en_i & ((^data_i ^ par_bit_i) != par_odd_i);
  assign fer_n = ~stop_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0; ovr_o <= 1'b0; per_o <= 1'b0; fer_o <= 1'b0; rdr_o <= '0;
    end else begin
      if (clr_i[0]) full_o <= 1'b0;
      if (clr_i[1]) ovr_o  <= 1'b0;
      if (clr_i[2]) per_o  <= 1'b0;
      if (clr_i[3]) fer_o  <= 1'b0;
      if (done_i) begin
        if (full_o || per_n || fer_n) begin
          if (full_o) ovr_o <= 1'b1;
          if (per_n)  per_o <= 1'b1;
          if (fer_n)  fer_o <= 1'b1;
        end else begin
          full_o <= 1'b1;
          rdr_o  <= data_i;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [4:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       full_o,
  output logic       ovr_o,
  output logic       per_o,
  output logic       fer_o,
  output logic       irq_rxi_o,
  output logic       irq_eri_o
);
  localparam int DATA_W = 8;
  localparam int OSR    = 16;

  rx_cfg_t           cfg_q;
  logic              rx_s, tick, done, par_bit, stop_bit, fsm_idle, any_err;
  logic [DATA_W-1:0] shift_data;
  logic [3:0]        clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (wr_i && !addr_i)   cfg_q <= rx_cfg_t'(wdata_i);
  end

  assign clr     = (wr_i && addr_i) ? wdata_i[3:0] : 4'b0;
  assign any_err = ovr_o | per_o | fer_o;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s));

  serial_rx_tick #(.DIV(DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick));

  serial_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_s), .lock_i(any_err),
    .cfg_i(cfg_q), .done_o(done), .data_o(shift_data),
    .par_bit_o(par_bit), .stop_bit_o(stop_bit), .idle_o(fsm_idle));

  serial_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i, .rst_ni, .done_i(done), .data_i(shift_data),
    .par_bit_i(par_bit), .stop_bit_i(stop_bit),
    .par_en_i(cfg_q.par_en), .par_odd_i(cfg_q.par_odd), .clr_i(clr),
    .full_o, .ovr_o, .per_o, .fer_o, .rdr_o(rdata_o));

  assign irq_rxi_o = full_o & cfg_q.rie;
  assign irq_eri_o = any_err & cfg_q.rie;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       full_i,
  input logic       ovr_i,
  input logic       per_i,
  input logic       fer_i,
  input logic [7:0] rdata_i,
  input logic       idle_i,
  input logic       par_en_i,
  input logic       rie_i,
  input logic       irq_eri_i
);
  logic err;
  assign err = ovr_i | per_i | fer_i;

  assert_full_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_i) |-> !err);
  assert_ovr_needs_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $past(full_i));
  assert_rdr_on_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_i) |-> $rose(full_i));
  assert_lock_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && idle_i) |=> idle_i);
  assert_per_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(per_i) |-> par_en_i);
  assert_eri_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_eri_i |-> rie_i);
endmodule

bind serial_rx_engine serial_rx_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_i(full_o), .ovr_i(ovr_o),
  .per_i(per_o), .fer_i(fer_o), .rdata_i(rdata_o), .idle_i(fsm_idle),
  .par_en_i(cfg_q.par_en), .rie_i(cfg_q.rie), .irq_eri_i(irq_eri_o));

// File: tb/sim_serial_rx_engine.sv
`timescale 1ns/1ps
module sim_serial_rx_engine;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic clk = 0, rst_n = 0, rx = 1, wr = 0, addr = 0;
  logic [4:0] wdata = 0;
  logic [7:0] rdata;
  logic full, ovr, per, fer, irq_rxi, irq_eri;

  always #10 clk = ~clk;

  serial_rx_engine #(.DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .full_o(full), .ovr_o(ovr),
    .per_o(per), .fer_o(fer), .irq_rxi_o(irq_rxi), .irq_eri_o(irq_eri));

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 0;
  // reference model state
  logic [7:0] m_data = 0;
  bit m_full = 0, m_ovr = 0, m_per = 0, m_fer = 0;
  bit c7 = 0, cpe = 0, codd = 0, cst2 = 0, crie = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2/R6 rdata", rdata, m_data);
    chk("R6 full", full, m_full);
    chk("R5 ovr", ovr, m_ovr);
    chk("R3 per", per, m_per);
    chk("R4 fer", fer, m_fer);
    chk("R7 irq_rxi", irq_rxi, m_full & crie);
    chk("R8 irq_eri", irq_eri, (m_ovr | m_per | m_fer) & crie);
  endtask

  always @(negedge clk) if (rst_n && cmp_en) cmp_all();

  task automatic wreg(bit a, logic [4:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    if (a == 0) {crie, cst2, codd, cpe, c7} = d;
    else begin
      if (d[0]) m_full = 0;
      if (d[1]) m_ovr = 0;
      if (d[2]) m_per = 0;
      if (d[3]) m_fer = 0;
    end
    @(negedge clk); wr = 0;
  endtask

  // bad_par flips the parity bit, stop1/stop2 give the stop-bit levels
  task automatic send(logic [7:0] d, bit bad_par, bit stop1, bit stop2v);
    int nb = c7 ? 7 : 8;
    logic [7:0] dm = c7 ? (d & 8'h7f) : d;
    bit p = (^dm) ^ codd ^ bad_par;
    bit pe, fe;
    cmp_en = 0;
    @(negedge clk); rx = 0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rx = dm[i]; repeat (BIT) @(negedge clk); end
    if (cpe) begin rx = p; repeat (BIT) @(negedge clk); end
    rx = stop1; repeat (BIT) @(negedge clk);
    if (cst2) begin rx = stop2v; repeat (BIT) @(negedge clk); end
    rx = 1; repeat (2 * BIT) @(negedge clk);
    if (!(m_ovr | m_per | m_fer)) begin
      pe = cpe && bad_par;
      fe = !stop1;
      if (m_full || pe || fe) begin
        m_ovr |= m_full; m_per |= pe; m_fer |= fe;
      end else begin
        m_full = 1; m_data = dm;
      end
    end
    cmp_en = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0); chk("R1 full", full, 0);
    chk("R1 errs", {ovr, per, fer}, 0); chk("R1 irqs", {irq_rxi, irq_eri}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    wreg(0, 5'b10000);              // R11: 8N1, rie
    send(8'hA5, 0, 1, 1);           // R2 R6 R7
    wreg(1, 5'b00001);              // R11 clear full
    wreg(0, 5'b10010);              // even parity
    send(8'h3C, 0, 1, 1);           // R3 good
    wreg(1, 5'b00001);
    wreg(0, 5'b10110);              // odd parity
    send(8'h81, 0, 1, 1);
    wreg(1, 5'b00001);
    send(8'h81, 1, 1, 1);           // R3 parity error, R8
    send(8'h55, 0, 1, 1);           // R9 locked: ignored
    wreg(1, 5'b00100);              // R9/R11 clear parity
    send(8'h55, 0, 1, 1);           // R9 resumes
    wreg(0, 5'b10000);
    send(8'h12, 0, 1, 1);           // R5 overrun, data kept
    wreg(1, 5'b01111);
    send(8'h77, 0, 0, 1);           // R4 framing
    wreg(1, 5'b01000);
    wreg(0, 5'b11001);              // R2 7-bit, R4 two stop bits
    send(8'hEB, 0, 1, 0);           // second stop low: no error
    wreg(1, 5'b00001);
    wreg(0, 5'b00000);              // rie off: R7 R8
    cmp_en = 0;                     // R10 short glitch
    @(negedge clk); rx = 0; repeat (3 * DIV) @(negedge clk); rx = 1;
    repeat (2 * BIT) @(negedge clk);
    cmp_en = 1;
    send(8'hC3, 0, 1, 1);           // R10 next frame good
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule